// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block is a serial master that writes and reads 8-bit configuration registers inside an LCD driver. The link has three wires: an active-low enable, a serial clock and one data line that both ends can drive. Each register access is one fixed 16-bit frame. The frame carries a 6-bit register address, a direction bit, one turnaround slot and 8 data bits. The slave takes the data line on every rising serial-clock edge. It acts on a frame only when exactly 16 rising edges occur while the enable is low.

Commands reach the block in two ways. A short internal queue takes commands from the surrounding logic. A boot list of register writes is played once after reset, before anything from the queue. The serial clock and the enable are shared with a touch-converter master. This block therefore raises a bus request and starts a frame only while the bus grant is high. A frame that has started always runs to its end. For a read, the master releases the data line from the turnaround slot onward. It collects the eight bits the slave returns and presents them with a one-cycle strobe.

Top module: `panel_cfg_writer`

## Requirements
- R1: During reset and in idle, the enable is high, the serial clock is low, the data line is not driven (`sda_oe`=0), `busy` is low and `cmd_full` is low.
- R2: Frame bit order is {addr[5:0] MSB first, rw (1=read, 0=write), turnaround driven 0, data[7:0] MSB first}. Each bit is placed on `sda_o` while the clock is low. Exactly 16 clock rises occur while the enable is low.
- R3: The clock low and high phases each last HALF_DIV system cycles. The enable falls together with the first low phase and rises HALF_DIV cycles after the 16th clock fall. A whole frame keeps the enable low for 33*HALF_DIV cycles.
- R4: A frame starts only on a cycle where `bus_grant` is high. Pending commands stay queued while `bus_grant` is low. Dropping the grant does not cut short a frame that has started.
- R5: In a read frame, `sda_oe` is low from the turnaround slot to the end of the frame, and `sda_i` is sampled on the eight clock rises that follow, MSB first. `rd_valid` pulses for one cycle, in the cycle the enable returns high, with the byte on `rd_data`.
- R6: `busy` is high exactly while the enable is low. `bus_req` is high while `busy` is high or any boot or queued command is pending.
- R7: After reset, BOOT_LEN write frames go out before any queued command, once each. Entry i has address 8+i and data 0x11*(i+1).
- R8: The queue holds FIFO_DEPTH commands, which go out in push order. `cmd_full` is high when the queue is full. A push while the queue is full is dropped.
- R9: In a write frame the master drives the data line for every slot, including the turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Push one command into the queue |
| cmd_rd | input | 1 | Command direction, 1 = read |
| cmd_addr | input | 6 | Command register address |
| cmd_wdata | input | 8 | Command write data |
| cmd_full | output | 1 | Queue full |
| bus_grant | input | 1 | Shared clock/enable granted to this master |
| bus_req | output | 1 | Request for the shared pins |
| busy | output | 1 | Frame in progress |
| ser_en_n | output | 1 | Serial enable, active low |
| ser_clk | output | 1 | Serial clock |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable |
| sda_i | input | 1 | Data line input value |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |

## Verification
The hardest case to reach is a queue that is full, together with a push that must be dropped. The same stretch must also show that no frame begins while the grant is low. The bench first waits for the boot list to drain. It then removes the grant and pushes one more command than the queue can hold. It holds that state for hundreds of cycles before restoring the grant. A later run drops the grant a few cycles after a frame has started, to show that the frame still completes. A bench-side slave drives read bytes after watching the clock falls on the pins, so each read returns a byte known from the frame count.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = ADDR_W + 2 + DATA_W;
    localparam int TURN_POS   = DATA_W;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL
    } eng_state_t;

    function automatic reg_cmd_t boot_entry(input int unsigned idx);
        reg_cmd_t c;
        c.rd   = 1'b0;
        c.addr = ADDR_W'(8 + idx);
        c.data = DATA_W'(8'h11 * (idx + 1));
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] pack_frame(input reg_cmd_t c);
        return {c.addr, c.rd, 1'b0, c.data};
    endfunction

endpackage

// File: rtl/panel_cmd_fifo.sv
module panel_cmd_fifo
    import panel_cfg_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  reg_cmd_t push_cmd,
    input  logic     pop,
    output reg_cmd_t head_cmd,
    output logic     not_empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    reg_cmd_t       mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [PW:0]    count;
    logic           do_push;

    assign full      = (count == (PW+1)'(DEPTH));
    assign not_empty = (count != '0);
    assign head_cmd  = mem[rd_ptr];
    assign do_push   = push && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_cmd;
                wr_ptr      <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);
    a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
    import panel_cfg_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pop,
    output reg_cmd_t cmd,
    output logic     valid
);
    localparam int IW = $clog2(LEN + 1);

    logic [IW-1:0] idx;

    assign valid = (idx < IW'(LEN));
    assign cmd   = boot_entry(32'(idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (pop && valid) begin
            idx <= idx + 1'b1;
        end
    end

    a_r7_pop_only_while_pending: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);

endmodule

// File: rtl/panel_frame_engine.sv
module panel_frame_engine
    import panel_cfg_pkg::*;
#(
    parameter int HALF_DIV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  reg_cmd_t          cmd,
    input  logic              sda_i,
    output logic              ser_en_n,
    output logic              ser_clk,
    output logic              sda_o,
    output logic              sda_oe,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(FRAME_BITS);

    eng_state_t              state;
    logic [CW-1:0]           div_cnt;
    logic                    phase_hi;
    logic [BW-1:0]           bit_idx;
    logic [BW-1:0]           next_idx;
    logic [FRAME_BITS-1:0]   frame_q;
    logic [FRAME_BITS-1:0]   frame_new;
    logic                    is_rd;
    logic [DATA_W-1:0]       shift_q;
    logic                    last_tick;

    assign last_tick = (div_cnt == CW'(HALF_DIV - 1));
    assign next_idx  = bit_idx - BW'(1);
    assign frame_new = pack_frame(cmd);
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            div_cnt  <= '0;
            phase_hi <= 1'b0;
            bit_idx  <= '0;
            frame_q  <= '0;
            is_rd    <= 1'b0;
            shift_q  <= '0;
            ser_en_n <= 1'b1;
            ser_clk  <= 1'b0;
            sda_o    <= 1'b0;
            sda_oe   <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SHIFT;
                        frame_q  <= frame_new;
                        is_rd    <= cmd.rd;
                        bit_idx  <= BW'(FRAME_BITS - 1);
                        div_cnt  <= '0;
                        phase_hi <= 1'b0;
                        ser_en_n <= 1'b0;
                        sda_o    <= frame_new[FRAME_BITS-1];
                        sda_oe   <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (phase_hi && div_cnt == '0 && is_rd && bit_idx < BW'(TURN_POS)) begin
                        shift_q <= {shift_q[DATA_W-2:0], sda_i};
                    end
                    if (last_tick) begin
                        div_cnt <= '0;
                        if (!phase_hi) begin
                            phase_hi <= 1'b1;
                            ser_clk  <= 1'b1;
                        end else begin
                            phase_hi <= 1'b0;
                            ser_clk  <= 1'b0;
                            if (bit_idx == '0) begin
                                state <= ST_TAIL;
                            end else begin
                                bit_idx <= next_idx;
                                sda_o   <= frame_q[next_idx];
                                sda_oe  <= !is_rd || (next_idx > BW'(TURN_POS));
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (last_tick) begin
                        div_cnt  <= '0;
                        state    <= ST_IDLE;
                        ser_en_n <= 1'b1;
                        sda_o    <= 1'b0;
                        sda_oe   <= 1'b0;
                        if (is_rd) begin
                            rd_valid <= 1'b1;
                            rd_data  <= shift_q;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: clock rises seen inside one enable-low window.
    logic       clk_d;
    logic [5:0] rise_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            clk_d <= ser_clk;
            if (ser_en_n && !ser_clk) begin
                rise_cnt <= '0;
            end else if (ser_clk && !clk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    a_r2_sixteen_rises: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_en_n) |-> (rise_cnt == 6'(FRAME_BITS)));
    a_r1_clk_low_while_disabled: assert property (@(posedge clk) disable iff (rst)
        ser_en_n |-> !ser_clk);
    a_r5_line_released_idle: assert property (@(posedge clk) disable iff (rst)
        ser_en_n |-> !sda_oe);
    a_r5_valid_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(ser_en_n));
    a_r6_busy_tracks_enable: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ser_en_n);

endmodule

// File: rtl/panel_cfg_writer.sv
module panel_cfg_writer
    import panel_cfg_pkg::*;
#(
    parameter int HALF_DIV   = 10,
    parameter int FIFO_DEPTH = 4,
    parameter int BOOT_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_push,
    input  logic       cmd_rd,
    input  logic [5:0] cmd_addr,
    input  logic [7:0] cmd_wdata,
    output logic       cmd_full,
    input  logic       bus_grant,
    output logic       bus_req,
    output logic       busy,
    output logic       ser_en_n,
    output logic       ser_clk,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic       sda_i,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    reg_cmd_t push_cmd, fifo_cmd, boot_cmd, src_cmd;
    logic     fifo_ne, boot_valid, src_valid, start, fifo_pop, boot_pop;

    assign push_cmd = '{rd: cmd_rd, addr: cmd_addr, data: cmd_wdata};

    panel_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_push),
        .push_cmd  (push_cmd),
        .pop       (fifo_pop),
        .head_cmd  (fifo_cmd),
        .not_empty (fifo_ne),
        .full      (cmd_full)
    );

    generate
        if (BOOT_LEN > 0) begin : g_boot
            panel_boot_seq #(.LEN(BOOT_LEN)) u_boot (
                .clk   (clk),
                .rst   (rst),
                .pop   (boot_pop),
                .cmd   (boot_cmd),
                .valid (boot_valid)
            );
        end else begin : g_no_boot
            assign boot_cmd   = '0;
            assign boot_valid = 1'b0;
        end
    endgenerate

    assign src_valid = boot_valid || fifo_ne;
    assign src_cmd   = boot_valid ? boot_cmd : fifo_cmd;
    assign start     = !busy && bus_grant && src_valid;
    assign boot_pop  = start && boot_valid;
    assign fifo_pop  = start && !boot_valid;
    assign bus_req   = busy || src_valid;

    panel_frame_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (src_cmd),
        .sda_i    (sda_i),
        .ser_en_n (ser_en_n),
        .ser_clk  (ser_clk),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    a_r4_start_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_en_n) |-> $past(bus_grant));
    a_r7_boot_before_queue: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !boot_valid);

endmodule

// File: tb/panel_cfg_writer_bench.sv
module panel_cfg_writer_bench;
    localparam int H     = 10;
    localparam int DEPTH = 4;
    localparam int BLEN  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_push = 1'b0;
    logic       cmd_rd = 1'b0;
    logic [5:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       bus_grant = 1'b1;
    logic       sda_in = 1'b1;
    logic       cmd_full, bus_req, busy, ser_en_n, ser_clk, sda_o, sda_oe, rd_valid;
    logic [7:0] rd_data;

    always #10 clk = ~clk;

    panel_cfg_writer u_panel_cfg_writer (
        .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_full(cmd_full),
        .bus_grant(bus_grant), .bus_req(bus_req), .busy(busy),
        .ser_en_n(ser_en_n), .ser_clk(ser_clk), .sda_o(sda_o), .sda_oe(sda_oe),
        .sda_i(sda_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] slave_byte(input int frame_no);
        return 8'hA5 ^ 8'(frame_no * 29);
    endfunction

    // Behavioural reference model
    logic [14:0] q[$];
    bit          armed = 0;
    bit          m_busy = 0;
    int          t = 0;
    int          boot_i = 0;
    int          done_frames = 0;
    bit          cur_rd = 0;
    bit          cur_boot = 0;
    logic [5:0]  cur_addr = '0;
    logic [7:0]  cur_data = '0;
    bit          m_rdv = 0;
    logic [7:0]  m_rdd = '0;
    bit          m_in_reset = 1;

    always @(posedge clk) begin
        int pre;
        logic [14:0] e;
        pre = q.size();
        armed <= 1'b1;
        if (rst) begin
            q.delete();
            m_busy = 0; t = 0; boot_i = 0; done_frames = 0; m_rdv = 0;
            m_in_reset = 1;
        end else begin
            m_in_reset = 0;
            m_rdv = 0;
            if (!m_busy) begin
                if (bus_grant && (boot_i < BLEN || q.size() > 0)) begin
                    if (boot_i < BLEN) begin
                        cur_rd = 0; cur_addr = 6'(8 + boot_i);
                        cur_data = 8'(8'h11 * (boot_i + 1)); cur_boot = 1;
                        boot_i++;
                    end else begin
                        e = q.pop_front();
                        {cur_rd, cur_addr, cur_data} = e;
                        cur_boot = 0;
                    end
                    m_busy = 1; t = 0;
                end
            end else begin
                t++;
                if (t == 33 * H) begin
                    m_busy = 0;
                    if (cur_rd) begin
                        m_rdv = 1;
                        m_rdd = slave_byte(done_frames);
                    end
                    done_frames++;
                end
            end
            if (cmd_push && pre < DEPTH) q.push_back({cmd_rd, cmd_addr, cmd_wdata});
        end
    end

    // Bench-side slave: returns a byte after the turnaround, changing on clock falls
    logic prev_clk = 1'b0;
    int   falls = 0;
    int   slave_frames = 0;
    logic prev_en = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!prev_en && ser_en_n) slave_frames++;
            if (ser_en_n) falls = 0;
            else if (prev_clk && !ser_clk) falls++;
            if (!ser_en_n && falls >= 8 && falls <= 15)
                sda_in = slave_byte(slave_frames)[15 - falls];
            else
                sda_in = 1'b1;
        end
        prev_clk = ser_clk;
        prev_en  = ser_en_n;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [15:0] w;
        int k;
        logic e_clk, e_oe, e_sda;
        if (armed && !finished) begin
            w = {cur_addr, cur_rd, 1'b0, cur_data};
            k = t / (2 * H);
            if (m_busy) begin
                e_clk = (t < 32 * H) && (((t / H) % 2) == 1);
                e_oe  = cur_rd ? (k < 7) : 1'b1;
                e_sda = (t < 32 * H) ? w[15 - k] : w[0];
            end else begin
                e_clk = 0; e_oe = 0; e_sda = 0;
            end
            if (m_in_reset) begin
                chk("R1 enable in reset", 32'(ser_en_n), 32'd1);
                chk("R1 clock in reset", 32'(ser_clk), 32'd0);
                chk("R1 oe in reset", 32'(sda_oe), 32'd0);
                chk("R1 busy in reset", 32'(busy), 32'd0);
                chk("R1 full in reset", 32'(cmd_full), 32'd0);
            end else begin
                chk((!m_busy && !bus_grant) ? "R4 enable held off" : "R3 enable window",
                    32'(ser_en_n), 32'(!m_busy));
                chk("R3 clock phase", 32'(ser_clk), 32'(e_clk));
                chk(cur_rd ? "R5 read release" : "R9 write drive", 32'(sda_oe), 32'(e_oe));
                if (e_oe && m_busy)
                    chk(cur_boot ? "R7 boot frame bit" : "R2 frame bit", 32'(sda_o), 32'(e_sda));
                chk("R6 busy", 32'(busy), 32'(m_busy));
                chk("R6 bus_req", 32'(bus_req), 32'(m_busy || boot_i < BLEN || q.size() > 0));
                chk("R8 full flag", 32'(cmd_full), 32'(q.size() == DEPTH));
                chk("R5 rd_valid", 32'(rd_valid), 32'(m_rdv));
                if (m_rdv) chk("R5 rd_data", 32'(rd_data), 32'(m_rdd));
            end
        end
    end

    task automatic push(input bit rd, input logic [5:0] a, input logic [7:0] d);
        cmd_push = 1; cmd_rd = rd; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_push = 0;
    endtask

    task automatic drain();
        while (busy || bus_req) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (50) @(negedge clk);
        push(0, 6'h21, 8'h5C);
        push(1, 6'h07, 8'h00);
        push(0, 6'h3F, 8'hFF);
        push(1, 6'h00, 8'h00);
        drain();
        // R4 and R8: grant withheld, queue overfilled
        bus_grant = 0;
        push(0, 6'h01, 8'h01);
        push(1, 6'h02, 8'h00);
        push(0, 6'h03, 8'h03);
        push(0, 6'h04, 8'h04);
        push(0, 6'h05, 8'h05);
        repeat (400) @(negedge clk);
        bus_grant = 1;
        drain();
        // R4: grant dropped during a frame that has already started
        push(1, 6'h2A, 8'h00);
        repeat (20) @(negedge clk);
        bus_grant = 0;
        push(0, 6'h15, 8'hA7);
        repeat (800) @(negedge clk);
        bus_grant = 1;
        drain();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

endmodule